// File: doc/BRIEF.md
# Fast System-Call Entry Unit

This block computes the architectural state change of a fast system-call entry on a 64-bit core that has both a legacy protected mode and a long mode. When `start` is pulsed, it samples the current mode, the call-enable bit, the configuration registers and the current program state. It then checks the entry preconditions in a fixed order. It reports either a fault code or a complete new state: the program counter, the return address, the saved flags, the new flags, and the code and stack segment selectors, bases, limits and attributes.

The interface is a plain start/done pair and has no back-pressure. A new request may be given on every cycle, including the cycle in which `done` is high. Each request produces exactly one `done` cycle, one clock after it is accepted. All results are registered and are valid while `done` is high. The unit does not fetch, decode or deliver the exception. The surrounding pipeline acts on `fault`.

Top module: `fastcall_entry`

## Requirements
- R1: `done` is high in exactly the cycle after a cycle in which `start` is high, and low otherwise. A request is accepted on every cycle. `fault` and all result outputs are registered and valid while `done` is high.
- R2: Preconditions are evaluated in this priority:
  - `sc_enable` low gives fault 1 (invalid opcode).
  - Otherwise, `pe_en` low gives fault 2 (general protection, code 0).
  - Otherwise, `lm_only` high with `long_active` low gives fault 1.
- R3: The new code selector is `sel_cfg[47:32]` with bits 1:0 forced to 0. The stack selector is that value plus 8, modulo 2^16. If either selector is zero, the fault is 2. This check runs after the R2 checks.
- R4: In long mode the target is `tgt64` when `code64` is high and `tgt_compat` otherwise. A target whose bits 63:47 are not all equal gives fault 1. This check runs last.
- R5: On a long-mode success:
  - `ret_addr` = `cur_pc` + `insn_len`.
  - `saved_flags` = `flags_in` with bit 16 cleared.
  - `flags_out` = `saved_flags` with every bit set in `flag_mask` cleared, then bit 1 set.
- R6: On a legacy-mode success:
  - `ret_addr` = zero-extended `cur_pc[31:0]` + `insn_len`, in 64 bits with no wrap at 32.
  - `next_pc` = zero-extended `sel_cfg[31:0]`.
  - `flags_out` = `flags_in` with bits 17, 16 and 9 cleared.
  - `saved_flags` keeps its previous value.
- R7: On success, both segments get base 0 and limit 0xFFFFFFFF.
  - Attributes use this layout: bit 15 granular, bit 14 default-32, bit 13 long, bit 7 present, bit 4 code/data, bits 3:0 type.
  - In long mode the code attribute is 0xA09B and the stack attribute is 0xA093.
  - In legacy mode the code attribute is 0xC09B and the stack attribute is 0xC093.
- R8: Fault codes are 0 none, 1 invalid opcode and 2 general protection. On any fault, every result output keeps the value it held before the request.
- R9: After reset, `done`, `fault` and every result output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; inputs are sampled in this cycle |
| sc_enable | input | 1 | Fast system-call enable bit |
| pe_en | input | 1 | Protected-mode enable |
| long_active | input | 1 | Long mode active |
| code64 | input | 1 | Current code runs in 64-bit mode (else compatibility) |
| lm_only | input | 1 | Vendor behaviour: entry allowed only in long mode |
| sel_cfg | input | 64 | Selector base in 47:32, legacy entry point in 31:0 |
| tgt64 | input | 64 | Long-mode target for 64-bit callers |
| tgt_compat | input | 64 | Long-mode target for compatibility callers |
| flag_mask | input | 64 | Flags cleared on long-mode entry |
| cur_pc | input | 64 | Current program counter |
| insn_len | input | 4 | Length of the calling instruction |
| flags_in | input | 64 | Current flags |
| done | output | 1 | Result valid |
| fault | output | 2 | 0 none, 1 invalid opcode, 2 general protection |
| next_pc | output | 64 | New program counter |
| ret_addr | output | 64 | Return address |
| saved_flags | output | 64 | Saved flags (long mode) |
| flags_out | output | 64 | New flags |
| code_sel | output | 16 | New code selector |
| code_base | output | 64 | Code segment base |
| code_limit | output | 32 | Code segment limit |
| code_attr | output | 16 | Code segment attributes |
| stack_sel | output | 16 | New stack selector |
| stack_base | output | 64 | Stack segment base |
| stack_limit | output | 32 | Stack segment limit |
| stack_attr | output | 16 | Stack segment attributes |

## Verification
The unit has only one pipeline register stage, so any internal error appears at the outputs in the `done` cycle of the request that triggered it. A fault decoded at the wrong priority shows up as the wrong `fault` code on exactly the vectors that fail two checks at once. Examples are enable off together with protection off, and vendor restriction together with protection off. A broken hold path shows up when a fault follows a success: the result outputs no longer match the earlier committed values. Off-by-one canonical bounds and selector wrap are probed with vectors placed right at those edges.

// File: rtl/fentry_pkg.sv
package fentry_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2
  } fault_e;

  // flag bit positions
  localparam int FLB_RSV1 = 1;
  localparam int FLB_IF   = 9;
  localparam int FLB_RF   = 16;
  localparam int FLB_VM   = 17;

  // descriptor attribute layout
  localparam int ATB_G    = 15;
  localparam int ATB_D    = 14;
  localparam int ATB_L    = 13;
  localparam int ATB_P    = 7;
  localparam int ATB_S    = 4;
  localparam logic [3:0] TYPE_CODE_ER_ACC = 4'hB;
  localparam logic [3:0] TYPE_DATA_RW_ACC = 4'h3;

  // selector configuration field
  localparam int SELF_LO  = 32;
  localparam int SEL_W    = 16;
  localparam int LIMIT_W  = 32;
endpackage

// File: rtl/fentry_target.sv
module fentry_target
  import fentry_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int VA_BITS = 48
) (
  input  logic [XLEN-1:0] tgt64,
  input  logic [XLEN-1:0] tgt_compat,
  input  logic            code64,
  output logic [XLEN-1:0] target,
  output logic            canon
);
  localparam int UP_W = XLEN - VA_BITS + 1;

  logic [UP_W-1:0] upper;

  always_comb begin
    target = code64 ? tgt64 : tgt_compat;
    upper  = target[XLEN-1:VA_BITS-1];
    canon  = (&upper) | ~(|upper);
  end
endmodule

// File: rtl/fentry_check.sv
module fentry_check
  import fentry_pkg::*;
(
  input  logic             sc_enable,
  input  logic             pe_en,
  input  logic             long_active,
  input  logic             lm_only,
  input  logic             canon,
  input  logic [SEL_W-1:0] sel_raw,
  output logic [SEL_W-1:0] cs_sel,
  output logic [SEL_W-1:0] ss_sel,
  output fault_e           fault
);
  always_comb begin
    cs_sel = {sel_raw[SEL_W-1:2], 2'b00};
    ss_sel = cs_sel + SEL_W'(8);
    if (!sc_enable)                      fault = FLT_UD;
    else if (!pe_en)                     fault = FLT_GP;
    else if (lm_only && !long_active)    fault = FLT_UD;
    else if (cs_sel == '0 || ss_sel == '0) fault = FLT_GP;
    else if (long_active && !canon)      fault = FLT_UD;
    else                                 fault = FLT_NONE;
  end
endmodule

// File: rtl/fentry_flags.sv
module fentry_flags
  import fentry_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LEN_W = 4
) (
  input  logic             long_active,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [LEN_W-1:0] insn_len,
  input  logic [XLEN-1:0]  flags_in,
  input  logic [XLEN-1:0]  flag_mask,
  output logic [XLEN-1:0]  ret_addr,
  output logic [XLEN-1:0]  saved,
  output logic [XLEN-1:0]  flags_out
);
  localparam logic [XLEN-1:0] RF_BIT  = XLEN'(1) << FLB_RF;
  localparam logic [XLEN-1:0] VM_BIT  = XLEN'(1) << FLB_VM;
  localparam logic [XLEN-1:0] IF_BIT  = XLEN'(1) << FLB_IF;
  localparam logic [XLEN-1:0] ONE_BIT = XLEN'(1) << FLB_RSV1;

  always_comb begin
    saved = flags_in & ~RF_BIT;
    if (long_active) begin
      ret_addr  = cur_pc + XLEN'(insn_len);
      flags_out = (saved & ~flag_mask) | ONE_BIT;
    end else begin
      ret_addr  = XLEN'(cur_pc[31:0]) + XLEN'(insn_len);
      flags_out = flags_in & ~(RF_BIT | VM_BIT | IF_BIT);
    end
  end
endmodule

// File: rtl/fentry_desc.sv
module fentry_desc
  import fentry_pkg::*;
#(
  parameter bit IS_CODE = 1'b1
) (
  input  logic        long_active,
  output logic [15:0] attr
);
  localparam logic [3:0] SEG_TYPE = IS_CODE ? TYPE_CODE_ER_ACC : TYPE_DATA_RW_ACC;

  always_comb begin
    attr          = '0;
    attr[3:0]     = SEG_TYPE;
    attr[ATB_S]   = 1'b1;
    attr[ATB_P]   = 1'b1;
    attr[ATB_G]   = 1'b1;
    attr[ATB_L]   = long_active;
    attr[ATB_D]   = ~long_active;
  end
endmodule

// File: rtl/fastcall_entry.sv
module fastcall_entry
  import fentry_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int VA_BITS = 48,
  parameter int LEN_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sc_enable,
  input  logic             pe_en,
  input  logic             long_active,
  input  logic             code64,
  input  logic             lm_only,
  input  logic [XLEN-1:0]  sel_cfg,
  input  logic [XLEN-1:0]  tgt64,
  input  logic [XLEN-1:0]  tgt_compat,
  input  logic [XLEN-1:0]  flag_mask,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [LEN_W-1:0] insn_len,
  input  logic [XLEN-1:0]  flags_in,
  output logic             done,
  output logic [1:0]       fault,
  output logic [XLEN-1:0]  next_pc,
  output logic [XLEN-1:0]  ret_addr,
  output logic [XLEN-1:0]  saved_flags,
  output logic [XLEN-1:0]  flags_out,
  output logic [15:0]      code_sel,
  output logic [XLEN-1:0]  code_base,
  output logic [31:0]      code_limit,
  output logic [15:0]      code_attr,
  output logic [15:0]      stack_sel,
  output logic [XLEN-1:0]  stack_base,
  output logic [31:0]      stack_limit,
  output logic [15:0]      stack_attr
);
  localparam int NSEG = 2;

  logic [XLEN-1:0]  lm_target, c_ret, c_saved, c_flags, c_pc;
  logic             c_canon;
  logic [SEL_W-1:0] c_cs, c_ss;
  fault_e           c_fault;
  logic [15:0]      c_attr [NSEG];

  fentry_target #(.XLEN(XLEN), .VA_BITS(VA_BITS)) u_target (
    .tgt64(tgt64), .tgt_compat(tgt_compat), .code64(code64),
    .target(lm_target), .canon(c_canon)
  );

  fentry_check u_check (
    .sc_enable(sc_enable), .pe_en(pe_en), .long_active(long_active),
    .lm_only(lm_only), .canon(c_canon),
    .sel_raw(sel_cfg[SELF_LO +: SEL_W]),
    .cs_sel(c_cs), .ss_sel(c_ss), .fault(c_fault)
  );

  fentry_flags #(.XLEN(XLEN), .LEN_W(LEN_W)) u_flags (
    .long_active(long_active), .cur_pc(cur_pc), .insn_len(insn_len),
    .flags_in(flags_in), .flag_mask(flag_mask),
    .ret_addr(c_ret), .saved(c_saved), .flags_out(c_flags)
  );

  // index 0 = code segment, index 1 = stack segment
  for (genvar g = 0; g < NSEG; g++) begin : g_desc
    fentry_desc #(.IS_CODE(g == 0)) u_desc (
      .long_active(long_active), .attr(c_attr[g])
    );
  end

  assign c_pc = long_active ? lm_target : XLEN'(sel_cfg[31:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done        <= 1'b0;
      fault       <= FLT_NONE;
      next_pc     <= '0;
      ret_addr    <= '0;
      saved_flags <= '0;
      flags_out   <= '0;
      code_sel    <= '0;
      code_base   <= '0;
      code_limit  <= '0;
      code_attr   <= '0;
      stack_sel   <= '0;
      stack_base  <= '0;
      stack_limit <= '0;
      stack_attr  <= '0;
    end else begin
      done <= start;
      if (start) begin
        fault <= c_fault;
        if (c_fault == FLT_NONE) begin
          next_pc     <= c_pc;
          ret_addr    <= c_ret;
          flags_out   <= c_flags;
          if (long_active) saved_flags <= c_saved;
          code_sel    <= c_cs;
          code_base   <= '0;
          code_limit  <= '1;
          code_attr   <= c_attr[0];
          stack_sel   <= c_ss;
          stack_base  <= '0;
          stack_limit <= '1;
          stack_attr  <= c_attr[1];
        end
      end
    end
  end
endmodule

// File: rtl/fentry_checker.sv
module fentry_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            sc_enable,
  input logic            pe_en,
  input logic            done,
  input logic [1:0]      fault,
  input logic [XLEN-1:0] next_pc,
  input logic [XLEN-1:0] ret_addr,
  input logic [XLEN-1:0] flags_out,
  input logic [15:0]     code_sel,
  input logic [XLEN-1:0] code_base,
  input logic [31:0]     code_limit,
  input logic [15:0]     code_attr,
  input logic [15:0]     stack_sel,
  input logic [XLEN-1:0] stack_base,
  input logic [31:0]     stack_limit
);
  assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_no_stray_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  assert_enable_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !sc_enable |=> fault == 2'd1);
  assert_pe_gp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && sc_enable && !pe_en |=> fault == 2'd2);
  assert_stack_after_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault == 2'd0 |-> stack_sel == code_sel + 16'd8 && code_sel[1:0] == 2'b00
                               && code_sel != 16'd0 && stack_sel != 16'd0);
  assert_bit1_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault == 2'd0 && code_attr[13] |-> flags_out[1]);
  assert_flat_segments_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault == 2'd0 |-> code_base == '0 && stack_base == '0
                               && code_limit == 32'hFFFF_FFFF && stack_limit == 32'hFFFF_FFFF);
  assert_fault_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault != 2'd0 |-> $stable(next_pc) && $stable(ret_addr) && $stable(flags_out)
                               && $stable(code_sel) && $stable(stack_sel) && $stable(code_attr));
endmodule

bind fastcall_entry fentry_checker #(.XLEN(XLEN)) u_fentry_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sc_enable(sc_enable), .pe_en(pe_en),
  .done(done), .fault(fault), .next_pc(next_pc), .ret_addr(ret_addr),
  .flags_out(flags_out), .code_sel(code_sel), .code_base(code_base),
  .code_limit(code_limit), .code_attr(code_attr), .stack_sel(stack_sel),
  .stack_base(stack_base), .stack_limit(stack_limit)
);

// File: tb/tb_fastcall_entry.sv
`timescale 1ns/1ps
module tb_fastcall_entry;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sc_enable = 1'b0, pe_en = 1'b0, long_active = 1'b0, code64 = 1'b0, lm_only = 1'b0;
  logic [63:0] sel_cfg = '0, tgt64 = '0, tgt_compat = '0, flag_mask = '0, cur_pc = '0, flags_in = '0;
  logic [3:0]  insn_len = '0;
  logic        done;
  logic [1:0]  fault;
  logic [63:0] next_pc, ret_addr, saved_flags, flags_out, code_base, stack_base;
  logic [15:0] code_sel, code_attr, stack_sel, stack_attr;
  logic [31:0] code_limit, stack_limit;

  always #10 clk = ~clk;

  fastcall_entry dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sc_enable(sc_enable), .pe_en(pe_en),
    .long_active(long_active), .code64(code64), .lm_only(lm_only), .sel_cfg(sel_cfg),
    .tgt64(tgt64), .tgt_compat(tgt_compat), .flag_mask(flag_mask), .cur_pc(cur_pc),
    .insn_len(insn_len), .flags_in(flags_in), .done(done), .fault(fault),
    .next_pc(next_pc), .ret_addr(ret_addr), .saved_flags(saved_flags), .flags_out(flags_out),
    .code_sel(code_sel), .code_base(code_base), .code_limit(code_limit), .code_attr(code_attr),
    .stack_sel(stack_sel), .stack_base(stack_base), .stack_limit(stack_limit),
    .stack_attr(stack_attr)
  );

  typedef struct packed {
    logic        en, pe, lm, c64, vend;
    logic [63:0] sel, t64, tcm, mask, pc;
    logic [3:0]  len;
    logic [63:0] fl;
    logic [1:0]  xf;
    logic [63:0] xpc;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R4 long, 64-bit caller
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 64'h0023_0010_1234_5678, 64'hFFFF_8000_0000_1000, 64'h0000_0000_8000_2000,
      64'h700, 64'h40_1000, 4'd2, 64'h1_0246, 2'd0, 64'hFFFF_8000_0000_1000, 4'd4},
    // R4 long, compatibility caller
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 64'h0023_0010_1234_5678, 64'hFFFF_8000_0000_1000, 64'h0000_0000_8000_2000,
      64'h700, 64'h1000, 4'd3, 64'h202, 2'd0, 64'h0000_0000_8000_2000, 4'd4},
    // R6 legacy
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 64'h0023_0010_1234_5678, 64'h0, 64'h0,
      64'h700, 64'h2000, 4'd2, 64'h3_0202, 2'd0, 64'h1234_5678, 4'd6},
    // R2 enable off beats everything
    '{1'b0,1'b0,1'b1,1'b1,1'b1, 64'h0023_0010_1234_5678, 64'h0, 64'h0, 64'h0, 64'h0, 4'd1, 64'h2, 2'd1, 64'h0, 4'd2},
    // R2 protection off beats vendor restriction
    '{1'b1,1'b0,1'b0,1'b0,1'b1, 64'h0023_0010_1234_5678, 64'h0, 64'h0, 64'h0, 64'h0, 4'd1, 64'h2, 2'd2, 64'h0, 4'd2},
    // R2 vendor restriction outside long mode
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 64'h0023_0010_1234_5678, 64'h0, 64'h0, 64'h0, 64'h0, 4'd1, 64'h2, 2'd1, 64'h0, 4'd2},
    // R3 code selector zero after RPL strip
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 64'h0000_0003_0000_0000, 64'h1000, 64'h0, 64'h0, 64'h0, 4'd1, 64'h2, 2'd2, 64'h0, 4'd3},
    // R3 stack selector wraps to zero
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 64'h0000_FFFB_0000_0000, 64'h1000, 64'h0, 64'h0, 64'h0, 4'd1, 64'h2, 2'd2, 64'h0, 4'd3},
    // R4 non-canonical 64-bit target
    '{1'b1,1'b1,1'b1,1'b1,1'b0, 64'h0000_0010_0000_0000, 64'h0000_8000_0000_0000, 64'h0, 64'h0, 64'h0, 4'd1, 64'h2, 2'd1, 64'h0, 4'd4},
    // R4 non-canonical compatibility target
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 64'h0000_0010_0000_0000, 64'h0, 64'hFFFF_0000_0000_0000, 64'h0, 64'h0, 4'd1, 64'h2, 2'd1, 64'h0, 4'd4},
    // R5 highest canonical target, full mask, RPL stripped
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 64'h0000_001B_0000_0000, 64'h0000_7FFF_FFFF_F000, 64'h0,
      64'hFFFF_FFFF_FFFF_FFFF, 64'h7000, 4'd5, 64'h5_0ED7, 2'd0, 64'h0000_7FFF_FFFF_F000, 4'd5},
    // R6 legacy return address carries past 32 bits
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 64'h0000_0008_CAFE_0000, 64'h0, 64'h0,
      64'h0, 64'hFFFF_FFFF_FFFF_FFF8, 4'd15, 64'h2_0002, 2'd0, 64'hCAFE_0000, 4'd6}
  };

  int n_chk = 0, n_bad = 0;
  logic [63:0] e_pc = '0, e_ret = '0, e_sav = '0, e_fl = '0;
  logic [15:0] e_cs = '0, e_ss = '0, e_csa = '0, e_ssa = '0;
  logic [31:0] e_lim = '0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    sc_enable = v.en; pe_en = v.pe; long_active = v.lm; code64 = v.c64; lm_only = v.vend;
    sel_cfg = v.sel; tgt64 = v.t64; tgt_compat = v.tcm; flag_mask = v.mask;
    cur_pc = v.pc; insn_len = v.len; flags_in = v.fl;
  endtask

  // expected state from the requirements
  task automatic model(input vec_t v);
    if (v.xf == 2'd0) begin
      e_pc  = v.xpc;
      e_cs  = {v.sel[47:34], 2'b00};
      e_ss  = e_cs + 16'd8;
      e_lim = 32'hFFFF_FFFF;
      if (v.lm) begin
        e_ret = v.pc + 64'(v.len);
        e_sav = v.fl & ~64'h1_0000;
        e_fl  = (e_sav & ~v.mask) | 64'h2;
        e_csa = 16'hA09B; e_ssa = 16'hA093;
      end else begin
        e_ret = 64'(v.pc[31:0]) + 64'(v.len);
        e_fl  = v.fl & ~64'h3_0200;
        e_csa = 16'hC09B; e_ssa = 16'hC093;
      end
    end
  endtask

  task automatic check_outs(input string req);
    chk(req, "next_pc", next_pc, e_pc);
    chk(req, "ret_addr", ret_addr, e_ret);
    chk(req, "saved_flags", saved_flags, e_sav);
    chk(req, "flags_out", flags_out, e_fl);
    chk(req, "code_sel", 64'(code_sel), 64'(e_cs));
    chk(req, "stack_sel", 64'(stack_sel), 64'(e_ss));
    chk(req, "code_attr", 64'(code_attr), 64'(e_csa));
    chk(req, "stack_attr", 64'(stack_attr), 64'(e_ssa));
    chk("R7", "code_base", code_base, 64'h0);
    chk("R7", "stack_base", stack_base, 64'h0);
    chk("R7", "code_limit", 64'(code_limit), 64'(e_lim));
    chk("R7", "stack_limit", 64'(stack_limit), 64'(e_lim));
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9", "done", 64'(done), 64'h0);
    chk("R9", "fault", 64'(fault), 64'h0);
    check_outs("R9");

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VECS[i].rq);
      drive(VECS[i]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1", "done", 64'(done), 64'h1);
      chk(rq, "fault", 64'(fault), 64'(VECS[i].xf));
      model(VECS[i]);
      check_outs(VECS[i].xf == 2'd0 ? rq : "R8");
      @(negedge clk);
      chk("R1", "done low", 64'(done), 64'h0);
    end

    // R1 back-to-back requests, no back-pressure
    drive(VECS[0]);
    start = 1'b1;
    @(negedge clk);
    drive(VECS[5]);
    chk("R1", "done first", 64'(done), 64'h1);
    model(VECS[0]);
    check_outs("R5");
    @(negedge clk);
    start = 1'b0;
    chk("R1", "done second", 64'(done), 64'h1);
    chk("R2", "fault second", 64'(fault), 64'h1);
    check_outs("R8");
    @(negedge clk);
    chk("R1", "done idle", 64'(done), 64'h0);

    // R6 legacy entry leaves the saved flags from the long-mode entry
    drive(VECS[2]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    model(VECS[2]);
    chk("R6", "saved kept", saved_flags, 64'h246);
    check_outs("R6");

    // R9 reset in mid-stream clears everything again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    e_pc = '0; e_ret = '0; e_sav = '0; e_fl = '0;
    e_cs = '0; e_ss = '0; e_csa = '0; e_ssa = '0; e_lim = '0;
    chk("R9", "done", 64'(done), 64'h0);
    check_outs("R9");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule